// File: doc/BRIEF.md
# Two-Bank Flash Program/Erase Sequencer

This block sits on the host side of a word-wide flash that holds two banks. A requester hands it one operation at a time: a word program, a sector erase, a block erase or a whole-bank erase. Each request carries a target word address and, for a program, a data word. The most significant address bit picks the bank.

The sequencer writes the unlock-and-command sequence that the flash expects over a synchronous bus port. A program takes four writes and an erase takes six. Once the last write is accepted, the flash runs its internal cycle. No further writes are sent until that cycle is over. The sequencer watches for the end of the cycle by reading one location again and again. On each read it looks at data bit 6, which the flash inverts on every read while it is busy.

If bit 6 keeps changing for too long, the sequencer makes two confirming reads before it declares a failure. After a program it reads the word back and compares it with the requested data. It then returns one response with a result code.

Top module: `flash_opseq`

## Requirements
- R1: `reqReady` is high only while no operation is in flight. A request is taken on a cycle where `reqValid` and `reqReady` are both high. Any `reqValid` seen while an operation is in flight is ignored until the response has been given.
- R2: A program (`reqOp`=0) issues exactly four writes, in this order: 00AAh at B|5555h, 0055h at B|2AAAh, 00A0h at B|5555h, then the request data at the request address. B is the bank bit, which is the request address MSB placed at the MSB.
- R3: An erase (`reqOp`=1 sector, 2 block, 3 bank) issues six writes. The first five are 00AAh at B|5555h, 0055h at B|2AAAh, 0080h at B|5555h, 00AAh at B|5555h and 0055h at B|2AAAh.
- R4: The sixth erase write depends on the operation. A sector erase writes 0030h at the request address with bits 10:0 cleared. A block erase writes 0050h at the request address with bits 14:0 cleared. A bank erase writes 0010h at B|5555h.
- R5: While `busValid` is high and `busReady` is low, `busValid`, `busWrite`, `busAddr` and `busWdata` hold their values.
- R6: After the last command write, the sequencer polls with reads in pairs. A program polls the target address, and an erase polls the sixth-write address. The operation counts as complete at the first pair whose two reads have equal bit 6.
- R7: No bus write occurs from the last command write until the response is given.
- R8: After MAX_POLLS pairs in which bit 6 differed, the sequencer makes two confirming reads. If these agree in bit 6, it treats the operation as complete. If they differ, it responds with an error and code 1 (timeout).
- R9: After a program completes, the sequencer reads the target word once. It responds with code 0 if the word equals the request data, and otherwise with an error and code 2 (verify mismatch).
- R10: `respValid` is a one-cycle pulse. An erase that completes responds with code 0 and `respErr` low.
- R11: Under reset, `reqReady` is high and `busValid` and `respValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer idle, request can be taken |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 bank erase |
| reqAddr | input | ADDR_W | Target word address; MSB selects the bank |
| reqData | input | DATA_W | Word to program |
| respValid | output | 1 | Response pulse |
| respErr | output | 1 | Operation failed |
| respCode | output | 2 | 0 ok, 1 timeout, 2 verify mismatch |
| busValid | output | 1 | Bus transfer offered |
| busReady | input | 1 | Flash side accepts the transfer |
| busWrite | output | 1 | 1 write, 0 read |
| busAddr | output | ADDR_W | Bus word address |
| busWdata | output | DATA_W | Write data |
| busRvalid | input | 1 | Read data valid; arrives at least one cycle after the read is accepted |
| busRdata | input | DATA_W | Read data |

## Verification
The bench uses a flash model that toggles bit 6 for a chosen number of reads, and a bus ready signal that stalls on every third cycle. With these it checks the following cases.

- Completion exactly on a pair boundary. A sequencer that ends early or late would make the wrong number of reads.
- Completion that lands during the confirming reads. A design without the confirmation step would report a false timeout.
- A flash that never finishes. This must give code 1.
- A program whose stored word differs from the request. This must give code 2.
- The address rounding for sector, block and bank erase, in both banks. A wrong mask or a dropped bank bit shows up in the recorded write list.
- A second request held on the port while the sequencer is busy. A sequencer that took it would show extra writes or a raised `reqReady`.

// File: rtl/flseq_pkg.sv
package flseq_pkg;
  typedef enum logic [1:0] {OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2, OP_BANK = 2'd3} opKind_e;
  typedef enum logic [1:0] {RC_OK = 2'd0, RC_TIMEOUT = 2'd1, RC_VERIFY = 2'd2} respCode_e;

  typedef struct packed {
    logic latchReq;
    logic stepInc;
    logic capFirst;
    logic pollInc;
    logic rdSel;
  } ctlStrobe_t;

  localparam logic [14:0] UNLOCK_LO_A = 15'h5555;
  localparam logic [14:0] UNLOCK_LO_B = 15'h2AAA;
  localparam logic [7:0]  KEY_FIRST   = 8'hAA;
  localparam logic [7:0]  KEY_SECOND  = 8'h55;
  localparam logic [7:0]  KEY_PROG    = 8'hA0;
  localparam logic [7:0]  KEY_ERASE   = 8'h80;
  localparam logic [7:0]  KEY_SECT    = 8'h30;
  localparam logic [7:0]  KEY_BLK     = 8'h50;
  localparam logic [7:0]  KEY_BANK    = 8'h10;
endpackage

// File: rtl/flseq_dp.sv
module flseq_dp
  import flseq_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 4096,
  parameter int SECT_BITS = 11,
  parameter int BLK_BITS  = 15,
  parameter int TOG_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strb,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] busRdata,
  output opKind_e           curOp,
  output logic              lastStep,
  output logic              toggleSame,
  output logic              pollExhausted,
  output logic              verifyOk,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata
);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam int PAD_W  = ADDR_W - 15;

  opKind_e           opR;
  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] dataR;
  logic [2:0]        stepR;
  logic              firstBit;
  logic [POLL_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opR      <= OP_PROG;
      addrR    <= '0;
      dataR    <= '0;
      stepR    <= '0;
      firstBit <= 1'b0;
      pollCnt  <= '0;
    end else begin
      if (strb.latchReq) begin
        opR     <= opKind_e'(reqOp);
        addrR   <= reqAddr;
        dataR   <= reqData;
        stepR   <= '0;
        pollCnt <= '0;
      end else begin
        if (strb.stepInc) stepR <= stepR + 3'd1;
        if (strb.pollInc) pollCnt <= pollCnt + POLL_W'(1);
      end
      if (strb.capFirst) firstBit <= busRdata[TOG_BIT];
    end
  end

  function automatic logic [DATA_W-1:0] keyWord(input logic [7:0] k);
    return {{(DATA_W-8){1'b0}}, k};
  endfunction

  logic [ADDR_W-1:0] bankBase, unlockA, unlockB, finalAddr, pollAddr;
  logic [7:0]        finalKey;
  assign bankBase = {addrR[ADDR_W-1], {(ADDR_W-1){1'b0}}};
  assign unlockA  = bankBase | {{PAD_W{1'b0}}, UNLOCK_LO_A};
  assign unlockB  = bankBase | {{PAD_W{1'b0}}, UNLOCK_LO_B};

  always_comb begin
    case (opR)
      OP_SECT: begin finalAddr = {addrR[ADDR_W-1:SECT_BITS], {SECT_BITS{1'b0}}}; finalKey = KEY_SECT; end
      OP_BLK:  begin finalAddr = {addrR[ADDR_W-1:BLK_BITS], {BLK_BITS{1'b0}}};   finalKey = KEY_BLK;  end
      OP_BANK: begin finalAddr = unlockA;                                         finalKey = KEY_BANK; end
      default: begin finalAddr = addrR;                                           finalKey = KEY_PROG; end
    endcase
  end

  assign pollAddr = (opR == OP_PROG) ? addrR : finalAddr;

  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdData;
  always_comb begin
    case (stepR)
      3'd0: begin cmdAddr = unlockA; cmdData = keyWord(KEY_FIRST);  end
      3'd1: begin cmdAddr = unlockB; cmdData = keyWord(KEY_SECOND); end
      3'd2: begin
        cmdAddr = unlockA;
        cmdData = keyWord((opR == OP_PROG) ? KEY_PROG : KEY_ERASE);
      end
      3'd3: begin
        if (opR == OP_PROG) begin cmdAddr = addrR; cmdData = dataR; end
        else begin cmdAddr = unlockA; cmdData = keyWord(KEY_FIRST); end
      end
      3'd4:    begin cmdAddr = unlockB;   cmdData = keyWord(KEY_SECOND); end
      default: begin cmdAddr = finalAddr; cmdData = keyWord(finalKey);   end
    endcase
  end

  assign busAddr       = strb.rdSel ? pollAddr : cmdAddr;
  assign busWdata      = cmdData;
  assign curOp         = opR;
  assign lastStep      = (opR == OP_PROG) ? (stepR == 3'd3) : (stepR == 3'd5);
  assign toggleSame    = (busRdata[TOG_BIT] == firstBit);
  assign pollExhausted = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign verifyOk      = (busRdata == dataR);
endmodule

// File: rtl/flseq_ctl.sv
module flseq_ctl
  import flseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       respValid,
  output logic       respErr,
  output logic [1:0] respCode,
  output logic       busValid,
  output logic       busWrite,
  input  logic       busReady,
  input  logic       busRvalid,
  input  opKind_e    curOp,
  input  logic       lastStep,
  input  logic       toggleSame,
  input  logic       pollExhausted,
  input  logic       verifyOk,
  output ctlStrobe_t strb
);
  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_POLL_A, S_POLL_B, S_CONF_A, S_CONF_B, S_VERIFY, S_RESP
  } seqState_e;

  seqState_e stateR, stateN;
  respCode_e codeR, codeN;
  logic      pend;
  logic      isRead, readDone;

  assign isRead   = (stateR == S_POLL_A) || (stateR == S_POLL_B) || (stateR == S_CONF_A) ||
                    (stateR == S_CONF_B) || (stateR == S_VERIFY);
  assign readDone = pend && busRvalid;

  assign reqReady  = (stateR == S_IDLE);
  assign respValid = (stateR == S_RESP);
  assign respCode  = codeR;
  assign respErr   = (codeR != RC_OK);
  assign busWrite  = (stateR == S_CMD);
  assign busValid  = busWrite || (isRead && !pend);

  always_comb begin
    stateN = stateR;
    codeN  = codeR;
    strb   = '0;
    strb.rdSel = isRead;
    case (stateR)
      S_IDLE: if (reqValid) begin
        strb.latchReq = 1'b1;
        codeN  = RC_OK;
        stateN = S_CMD;
      end
      S_CMD: if (busReady) begin
        strb.stepInc = 1'b1;
        if (lastStep) stateN = S_POLL_A;
      end
      S_POLL_A: if (readDone) begin
        strb.capFirst = 1'b1;
        stateN = S_POLL_B;
      end
      S_POLL_B: if (readDone) begin
        if (toggleSame)          stateN = (curOp == OP_PROG) ? S_VERIFY : S_RESP;
        else if (pollExhausted)  stateN = S_CONF_A;
        else begin
          strb.pollInc = 1'b1;
          stateN = S_POLL_A;
        end
      end
      S_CONF_A: if (readDone) begin
        strb.capFirst = 1'b1;
        stateN = S_CONF_B;
      end
      S_CONF_B: if (readDone) begin
        if (toggleSame) stateN = (curOp == OP_PROG) ? S_VERIFY : S_RESP;
        else begin
          codeN  = RC_TIMEOUT;
          stateN = S_RESP;
        end
      end
      S_VERIFY: if (readDone) begin
        codeN  = verifyOk ? RC_OK : RC_VERIFY;
        stateN = S_RESP;
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stateR <= S_IDLE;
      codeR  <= RC_OK;
      pend   <= 1'b0;
    end else begin
      stateR <= stateN;
      codeR  <= codeN;
      if (busValid && busReady && !busWrite) pend <= 1'b1;
      else if (readDone)                     pend <= 1'b0;
    end
  end

  // R1: a taken request closes the request port on the next cycle
  p_one_inflight_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady |=> !reqReady);
  // R10: the response lasts exactly one cycle
  p_resp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid);
  // R10: no error flag with a zero code
  p_ok_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    respValid && !respErr |-> respCode == 2'd0);
  // R9: a verify mismatch can only follow a program
  p_verify_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
    respValid && respCode == 2'd2 |-> curOp == OP_PROG);
endmodule

// File: rtl/flash_opseq.sv
module flash_opseq
  import flseq_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 4096,
  parameter int SECT_BITS = 11,
  parameter int BLK_BITS  = 15,
  parameter int TOG_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              respValid,
  output logic              respErr,
  output logic [1:0]        respCode,
  output logic              busValid,
  input  logic              busReady,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busRvalid,
  input  logic [DATA_W-1:0] busRdata
);
  ctlStrobe_t strb;
  opKind_e    curOp;
  logic       lastStep, toggleSame, pollExhausted, verifyOk;

  flseq_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .respValid(respValid), .respErr(respErr), .respCode(respCode),
    .busValid(busValid), .busWrite(busWrite), .busReady(busReady), .busRvalid(busRvalid),
    .curOp(curOp), .lastStep(lastStep), .toggleSame(toggleSame),
    .pollExhausted(pollExhausted), .verifyOk(verifyOk), .strb(strb)
  );

  flseq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_POLLS(MAX_POLLS),
    .SECT_BITS(SECT_BITS), .BLK_BITS(BLK_BITS), .TOG_BIT(TOG_BIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .busRdata(busRdata), .curOp(curOp), .lastStep(lastStep),
    .toggleSame(toggleSame), .pollExhausted(pollExhausted), .verifyOk(verifyOk),
    .busAddr(busAddr), .busWdata(busWdata)
  );

  // R5: a stalled transfer holds still
  p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busValid && !busReady |=> busValid && $stable(busWrite) && $stable(busAddr) && $stable(busWdata));
endmodule

// File: tb/flash_opseq_test.sv
module flash_opseq_test;
  localparam int AW = 21;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0;
  logic reqValid = 0, reqReady;
  logic [1:0] reqOp = 0;
  logic [AW-1:0] reqAddr = 0;
  logic [DW-1:0] reqData = 0;
  logic respValid, respErr;
  logic [1:0] respCode;
  logic busValid, busWrite;
  logic busReady = 0, busRvalid = 0;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata, busRdata = 0;

  flash_opseq #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(4)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .respValid(respValid), .respErr(respErr),
    .respCode(respCode), .busValid(busValid), .busReady(busReady), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRvalid(busRvalid), .busRdata(busRdata)
  );

  always #5 clk = ~clk;

  int checks = 0, failures = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural flash + bus model
  logic [DW-1:0] mem [logic [AW-1:0]];
  logic [AW-1:0] wrA[$], rdA[$];
  logic [DW-1:0] wrD[$];
  int cyc = 0, expWrites = 0, planBusy = 0, busyLeft = 0, rdCount = 0, wrAfterLast = 0;
  logic [DW-1:0] corrupt = 0, rdVal = 0;
  bit rdDue = 0, tog = 0, inFlight = 0, gotResp = 0, errSeen = 0, ended = 0;
  logic [1:0] codeSeen = 0;

  always @(negedge clk) begin
    cyc++;
    busRvalid = 0;
    if (rdDue) begin busRvalid = 1; busRdata = rdVal; rdDue = 0; end
    busReady = (cyc % 3) != 1;
    if (rst_n) begin
      // every-cycle reference for the request port (R1)
      if (reqReady !== !inFlight) check(0, "R1", "reqReady vs model", reqReady, !inFlight);
      else checks++;
      if (reqValid && reqReady) inFlight = 1;
      if (respValid) begin
        inFlight = 0; gotResp = 1; errSeen = respErr; codeSeen = respCode;
      end
      if (busValid && busReady) begin
        if (busWrite) begin
          if (wrA.size() >= expWrites) wrAfterLast++;
          wrA.push_back(busAddr); wrD.push_back(busWdata);
          if (wrA.size() == expWrites) begin
            busyLeft = planBusy;
            if (expWrites == 4) mem[busAddr] = busWdata ^ corrupt;
            else mem.delete();
          end
        end else begin
          rdCount++; rdA.push_back(busAddr);
          if (busyLeft > 0) begin busyLeft--; tog = ~tog; rdVal = tog ? 16'h0040 : 16'h0000; end
          else rdVal = mem.exists(busAddr) ? mem[busAddr] : 16'hFFFF;
          rdDue = 1;
        end
      end
    end
  end

  logic [AW-1:0] eA[$];
  logic [DW-1:0] eD[$];
  logic [AW-1:0] ePoll;

  task automatic expect_seq(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [AW-1:0] b = {a[AW-1], 20'h0};
    eA = {}; eD = {};
    eA.push_back(b | 21'h5555); eD.push_back(16'h00AA);
    eA.push_back(b | 21'h2AAA); eD.push_back(16'h0055);
    if (op == 0) begin
      eA.push_back(b | 21'h5555); eD.push_back(16'h00A0);
      eA.push_back(a); eD.push_back(d); ePoll = a;
    end else begin
      eA.push_back(b | 21'h5555); eD.push_back(16'h0080);
      eA.push_back(b | 21'h5555); eD.push_back(16'h00AA);
      eA.push_back(b | 21'h2AAA); eD.push_back(16'h0055);
      case (op)
        2'd1: begin ePoll = a & ~21'h7FF;  eD.push_back(16'h0030); end
        2'd2: begin ePoll = a & ~21'h7FFF; eD.push_back(16'h0050); end
        default: begin ePoll = b | 21'h5555; eD.push_back(16'h0010); end
      endcase
      eA.push_back(ePoll);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int busy, input logic [DW-1:0] corr, input logic [1:0] expCode,
                        input int expReads, input bit junk, input string req);
    string seqReq = (op == 0) ? "R2" : "R3";
    expect_seq(op, a, d);
    @(posedge clk); #2;
    wrA = {}; wrD = {}; rdA = {}; rdCount = 0; wrAfterLast = 0; gotResp = 0;
    expWrites = (op == 0) ? 4 : 6; planBusy = busy; corrupt = corr;
    reqOp = op; reqAddr = a; reqData = d; reqValid = 1;
    do @(negedge clk); while (!reqReady);
    @(posedge clk); #2;
    if (junk) begin
      // R1: a second request held while busy must be ignored
      reqOp = 2'd3; reqAddr = 21'h000777; reqData = 16'h5A5A;
      repeat (6) @(posedge clk);
      #2;
    end
    reqValid = 0;
    while (!gotResp) @(negedge clk);
    #1;
    check(wrA.size() == expWrites, seqReq, "write count", wrA.size(), expWrites);
    for (int i = 0; i < wrA.size() && i < eA.size(); i++) begin
      string r = (op != 0 && i == 5) ? "R4" : seqReq;
      check(wrA[i] == eA[i], r, $sformatf("write %0d addr", i), wrA[i], eA[i]);
      check(wrD[i] == eD[i], r, $sformatf("write %0d data", i), wrD[i], eD[i]);
    end
    check(wrAfterLast == 0, "R7", "writes after last command", wrAfterLast, 0);
    check(rdCount == expReads, req, "read count", rdCount, expReads);
    foreach (rdA[i]) check(rdA[i] == ePoll, "R6", "poll address", rdA[i], ePoll);
    check(codeSeen == expCode, req, "response code", codeSeen, expCode);
    check(errSeen == (expCode != 0), req, "response error flag", errSeen, expCode != 0);
    @(negedge clk);
    check(!respValid, "R10", "response pulse width", respValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(reqReady == 1, "R11", "reqReady in reset", reqReady, 1);
    check(busValid == 0, "R11", "busValid in reset", busValid, 0);
    check(respValid == 0, "R11", "respValid in reset", respValid, 0);
    @(posedge clk); #2 rst_n = 1;
    // R2 R6 R9: program, busy 4 reads -> 3 pairs + verify
    run_op(2'd0, 21'h001234, 16'hBEEF, 4, 16'h0000, 2'd0, 7, 1'b1, "R9");
    // R2 bank bit, immediate completion
    run_op(2'd0, 21'h1FFFFF, 16'h1234, 0, 16'h0000, 2'd0, 3, 1'b0, "R6");
    // R9 verify mismatch
    run_op(2'd0, 21'h0ABCDE, 16'hC3C3, 2, 16'h0100, 2'd2, 5, 1'b0, "R9");
    // R4 sector erase in bank 1, R10 ok
    run_op(2'd1, 21'h1ABCDE, 16'h0000, 6, 16'h0000, 2'd0, 8, 1'b1, "R10");
    // R4 block erase in bank 0
    run_op(2'd2, 21'h0ABCDE, 16'h0000, 0, 16'h0000, 2'd0, 2, 1'b0, "R6");
    // R8 completion during confirming reads of a bank erase
    run_op(2'd3, 21'h1F0000, 16'h0000, 8, 16'h0000, 2'd0, 10, 1'b0, "R8");
    // R8 real timeout
    run_op(2'd1, 21'h012345, 16'h0000, 100, 16'h0000, 2'd1, 10, 1'b0, "R8");
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1500000;
    if (!ended) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule